// File: doc/BRIEF.md
# Masked State Save Sequencer

This block dumps a selected set of processor state components into a save area in memory. A single-cycle start pulse latches the save-area base address, two 32-bit request-mask halves, the enabled-features register and a per-component "in initial state" vector. A component takes part only when its bit is set in both the request mask and the enabled-features register. The sequencer reads each selected component through a simple per-component read port and issues 64-bit write beats over a request/grant port.

Every component has a fixed place in the save area that does not depend on which other components are selected. Unselected components are skipped without touching their memory. A reserved software window inside the first 512 bytes is never written. After the last component, a header beat records which saved components are not in their initial state. One cycle after the header beat is granted, a single-cycle done pulse ends the operation.

Top module: `state_save_seq`

## Requirements
- R1: The effective selection is {mask_hi[30:0], mask_lo[31:0]} ANDed with feat_en[62:0] and limited to components 0..NCOMP-1. mask_hi[31] and feat_en[63] have no effect.
- R2: Selected components are saved in ascending index order, and each component's beats are written at ascending addresses.
- R3: The save-area layout is fixed relative to the base. Component 0 takes 20 beats at offset 0. Component 1 takes 38 beats at offset 160. A component i of 2 or higher takes EXT_BEATS beats at offset 576 + (i-2)*EXT_STRIDE. No offset depends on the selection.
- R4: A component whose effective bit is 0 gets no write anywhere in its save area.
- R5: No write ever lands in byte offsets 464 to 511 of the save area.
- R6: After all components, exactly one header beat is written at base+512. Bit i of that beat is (selected i AND NOT comp_init[i]), and bit 63 is 0.
- R7: base[5:0] is ignored, so the save area always starts on a 64-byte boundary.
- R8: While wr_req is high and wr_gnt is low, wr_req stays high and wr_addr and wr_data hold their values into the next cycle.
- R9: done is low out of reset. It pulses for exactly one cycle, in the cycle after the header beat is granted. A start pulse during an operation is ignored.
- R10: With an effective selection of zero, the only write is the header beat.
- R11: The data of beat b of component i is rd_data sampled while rd_comp=i and rd_beat=b. wr_be is 8'hFF on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a save; latches all operands |
| base | input | ADDR_W | Save-area base byte address |
| mask_lo | input | 32 | Request mask, components 31..0 |
| mask_hi | input | 32 | Request mask, bits 62..32 in [30:0] |
| feat_en | input | 64 | Enabled-features register |
| comp_init | input | 63 | 1 = component is in its initial state |
| rd_comp | output | 6 | Component index on the read port |
| rd_beat | output | 6 | Beat index on the read port |
| rd_data | input | 64 | Component data for rd_comp/rd_beat |
| wr_req | output | 1 | Write request |
| wr_gnt | input | 1 | Write grant |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 64 | Write data |
| wr_be | output | 8 | Write byte enables |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with NCOMP=10, EXT_BEATS=2 and EXT_STRIDE=128. With these values a full save takes only 75 beats, so many random operations fit in the run. The highest component (index 9) and the filtering of mask bits above it are easy to reach. The extended areas also leave gaps that a shifted offset would fall into. Random grant rates put stalls on every kind of beat, including the header.

// File: rtl/state_save_seq.sv
module state_save_seq #(
  parameter int ADDR_W     = 32,
  parameter int NCOMP      = 63,
  parameter int EXT_BEATS  = 4,
  parameter int EXT_STRIDE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [31:0]       mask_lo,
  input  logic [31:0]       mask_hi,
  input  logic [63:0]       feat_en,
  input  logic [62:0]       comp_init,
  output logic [5:0]        rd_comp,
  output logic [5:0]        rd_beat,
  input  logic [63:0]       rd_data,
  output logic              wr_req,
  input  logic              wr_gnt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [63:0]       wr_data,
  output logic [7:0]        wr_be,
  output logic              done
);
  localparam int HDR_OFF  = 512;
  localparam int EXT_BASE = 576;
  localparam logic [63:0] NMASK = (64'd1 << NCOMP) - 64'd1;
  localparam logic [5:0]  LASTC = 6'(NCOMP - 1);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_WR, S_HDR, S_DONE} st_t;
  st_t st;

  logic [62:0]       sel, hdr;
  logic [ADDR_W-1:0] base_r;
  logic [5:0]        idx, beat;

  function automatic logic [ADDR_W-1:0] comp_off(input logic [5:0] i);
    case (i)
      6'd0:    return '0;
      6'd1:    return ADDR_W'(160);
      default: return ADDR_W'(EXT_BASE + (int'(i) - 2) * EXT_STRIDE);
    endcase
  endfunction

  function automatic logic [5:0] comp_len(input logic [5:0] i);
    case (i)
      6'd0:    return 6'd20;
      6'd1:    return 6'd38;
      default: return 6'(EXT_BEATS);
    endcase
  endfunction

  wire [62:0] eff       = {mask_hi[30:0], mask_lo} & feat_en[62:0] & NMASK[62:0];
  wire        last_beat = beat == comp_len(idx) - 6'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; sel <= '0; hdr <= '0; base_r <= '0; idx <= '0; beat <= '0;
    end else
      case (st)
        S_IDLE: if (start) begin
          sel    <= eff;
          hdr    <= eff & ~comp_init;
          base_r <= {base[ADDR_W-1:6], 6'b0};
          idx    <= '0;
          beat   <= '0;
          st     <= S_SCAN;
        end
        S_SCAN:
          if (sel[idx]) begin
            beat <= '0;
            st   <= S_WR;
          end else if (idx == LASTC) st <= S_HDR;
          else idx <= idx + 6'd1;
        S_WR: if (wr_gnt) begin
          if (last_beat) begin
            beat <= '0;
            if (idx == LASTC) st <= S_HDR;
            else begin
              idx <= idx + 6'd1;
              st  <= S_SCAN;
            end
          end else beat <= beat + 6'd1;
        end
        S_HDR:  if (wr_gnt) st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase

  assign rd_comp = idx;
  assign rd_beat = beat;
  assign wr_req  = st == S_WR || st == S_HDR;
  assign wr_addr = st == S_HDR ? base_r + ADDR_W'(HDR_OFF)
                               : base_r + comp_off(idx) + ADDR_W'({beat, 3'b000});
  assign wr_data = st == S_HDR ? {1'b0, hdr} : rd_data;
  assign wr_be   = 8'hFF;
  assign done    = st == S_DONE;

  wire [ADDR_W-1:0] rel = wr_addr - base_r;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_gnt |=> wr_req && $stable(wr_addr) && $stable(wr_data));
  p_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !(rel >= ADDR_W'(464) && rel < ADDR_W'(512)));
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_after_hdr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_req && wr_gnt && rel == ADDR_W'(HDR_OFF)));
  p_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_addr[2:0] == 3'b000 && wr_be == 8'hFF);
  p_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && rel != ADDR_W'(HDR_OFF) |-> sel[rd_comp]);
endmodule

// File: tb/state_save_seq_tb.sv
module state_save_seq_tb;
  localparam int AW = 32, NC = 10, EB = 2, ES = 128;

  logic clk = 0, rst_n = 0, start = 0, wr_gnt = 0;
  logic [AW-1:0] base = '0;
  logic [31:0] mask_lo = '0, mask_hi = '0;
  logic [63:0] feat_en = '0;
  logic [62:0] comp_init = '0;
  logic [5:0] rd_comp, rd_beat;
  logic [63:0] rd_data, wr_data;
  logic wr_req, done;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_be;

  int total = 0, bad = 0;
  logic [AW-1:0] ea [0:127];
  logic [63:0]   ed [0:127];
  int n_exp;

  always #2 clk = ~clk;

  function automatic logic [63:0] dat(input int c, input int b);
    return {8'(c), 8'(b), 16'hC0DE, 32'(c * 977 + b * 131 + 7)};
  endfunction
  assign rd_data = dat(int'(rd_comp), int'(rd_beat));

  state_save_seq #(.ADDR_W(AW), .NCOMP(NC), .EXT_BEATS(EB), .EXT_STRIDE(ES)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .mask_lo(mask_lo),
    .mask_hi(mask_hi), .feat_en(feat_en), .comp_init(comp_init), .rd_comp(rd_comp),
    .rd_beat(rd_beat), .rd_data(rd_data), .wr_req(wr_req), .wr_gnt(wr_gnt),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .done(done));

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic int off_of(input int c);
    return c == 0 ? 0 : c == 1 ? 160 : 576 + (c - 2) * ES;
  endfunction
  function automatic int len_of(input int c);
    return c == 0 ? 20 : c == 1 ? 38 : EB;
  endfunction

  task automatic run_op(input logic [AW-1:0] b, input logic [31:0] lo, input logic [31:0] hi,
                        input logic [63:0] en, input logic [62:0] ini, input int pct,
                        input bit busy_start);
    logic [62:0] eff;
    logic [AW-1:0] b0, pa;
    logic [63:0] pd;
    bit pstall = 0, hdr_prev = 0, gotd = 0, rsv_ok = 1;
    int k = 0;
    eff = ({hi[30:0], lo} & en[62:0]) & ((63'd1 << NC) - 63'd1);
    b0 = {b[AW-1:6], 6'b0};
    n_exp = 0;
    for (int c = 0; c < NC; c++)
      if (eff[c])
        for (int j = 0; j < len_of(c); j++) begin
          ea[n_exp] = b0 + AW'(off_of(c) + 8 * j);
          ed[n_exp] = dat(c, j);
          n_exp++;
        end
    ea[n_exp] = b0 + AW'(512);
    ed[n_exp] = {1'b0, eff & ~ini};
    n_exp++;
    @(negedge clk);
    base = b; mask_lo = lo; mask_hi = hi; feat_en = en; comp_init = ini; start = 1;
    for (int cyc = 0; cyc < 3000 && !gotd; cyc++) begin
      @(negedge clk);
      start = busy_start && cyc == 6;
      mask_lo = $urandom; mask_hi = $urandom; base = $urandom; comp_init = {$urandom, $urandom};
      wr_gnt = ($urandom % 100) < pct;
      #1;
      if (pstall) begin
        check(wr_req && wr_addr == pa && wr_data == pd, "R8 hold during stall", wr_addr, pa);
      end
      if (done) begin
        gotd = 1;
        check(hdr_prev, "R9 done right after header grant", 64'(done), 64'(hdr_prev));
      end
      hdr_prev = 0;
      if (wr_req && wr_gnt) begin
        if (int'(wr_addr - b0) >= 464 && int'(wr_addr - b0) < 512) rsv_ok = 0;
        if (k < n_exp)
          check(wr_addr == ea[k] && wr_data == ed[k] && wr_be == 8'hFF,
                "R1 R2 R3 R4 R6 R7 R11 write", {wr_addr, wr_data[31:0]}, {ea[k], ed[k][31:0]});
        else check(0, "R4 R10 extra write", 64'(wr_addr), 64'(k));
        hdr_prev = (k == n_exp - 1);
        k++;
      end
      pstall = wr_req && !wr_gnt;
      pa = wr_addr; pd = wr_data;
    end
    wr_gnt = 0; start = 0;
    check(gotd, "R9 done seen", 64'(gotd), 64'd1);
    check(k == n_exp, "R4 R10 write count", 64'(k), 64'(n_exp));
    check(rsv_ok, "R5 reserved window untouched", 64'(rsv_ok), 64'd1);
    @(negedge clk); #1;
    check(!done, "R9 done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    #1;
    check(!wr_req && !done, "R9 reset state", {62'd0, wr_req, done}, 64'd0);
    rst_n = 1;
    run_op(32'h1000_0000, '1, '1, '1, '0, 100, 0);
    run_op(32'h2000_0040, 32'h0, 32'h0, '1, '0, 70, 0);
    run_op(32'h2000_0080, 32'h0, 32'h8000_0000, 64'h8000_0000_0000_0000, '0, 60, 0);
    run_op(32'h3000_0000, 32'h0000_0220, 32'h0, '1, 63'h20, 50, 0);
    run_op(32'h3000_013F, 32'h3, 32'h0, 64'h2, 63'h0, 80, 0);
    run_op(32'h4000_0000, 32'h0000_03FF, 32'hFFFF_FFFF, 64'h0000_0000_0000_03F5, 63'h1, 40, 1);
    for (int t = 0; t < 20; t++)
      run_op($urandom, $urandom, $urandom, {$urandom, $urandom}, {$urandom, $urandom},
             20 + $urandom % 81, t[0]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired R9 act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule